// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Layer with Winner-Take-All Inhibition

This block holds the membrane state of a layer of leaky integrate-and-fire neurons and advances it by one time step whenever the `tick` strobe is high (one strobe per millisecond of model time). For every time step, an upstream stage supplies one accumulated synaptic current per neuron. Each neuron also has its own firing threshold, supplied by a separate adaptation stage. On a tick, each neuron's potential loses a fraction of itself toward the resting level of zero. The leak is a right shift by a programmable amount, so no multiplier is needed. The neuron's input current is then added.

When one or more neurons reach their threshold on a tick, a single winner is chosen: the neuron with the lowest index. The winner spikes, returns to rest and then sits out a programmable number of ticks. Every other neuron in the layer is cleared to rest on the same tick, which forms the competitive inhibition path. The layer reports the winner as a one-hot vector and as a binary index, and it exposes every membrane potential so that later stages can read them. The default size is 300 neurons, matching a layer fed by a 576-input fully connected synapse array.

Top module: `lif_wta_layer`

## Requirements
- R1: On a tick, a neuron that is not refractory takes the next potential `v - (v >> leak_shift) + in`, with all values unsigned. A `leak_shift` of 0 removes the whole previous potential, so the next potential equals the input.
- R2: The sum in R1 saturates at 2^VW-1 and never wraps.
- R3: A non-refractory neuron whose next potential is greater than or equal to its own threshold is a candidate. The winning neuron's potential is 0 after the tick.
- R4: The winner loads a refractory count of `refr_len`. On each of the following `refr_len` ticks, that neuron's potential stays 0, its input is ignored and it cannot fire. A `refr_len` of 0 means no hold.
- R5: When several neurons are candidates on the same tick, only the one with the lowest index fires.
- R6: On a tick with a winner, every other neuron's potential is cleared to 0 on that same tick. These neurons gain no refractory hold.
- R7: In the cycle after a tick, `fire_vec` has exactly bit i set for winner i, `fire_idx` equals i and `fire_valid` is 1. In every other cycle, and on ticks without a winner, all three are 0.
- R8: In a cycle without a tick, no potential and no refractory count changes.
- R9: While reset is asserted, all potentials, refractory counts and fire outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Advance the layer by one time step |
| leak_shift | input | SW | Right-shift amount used for the leak |
| refr_len | input | RW | Refractory length in ticks |
| syn_in | input | N*IW | Input current; neuron i at bits [i*IW +: IW] |
| thresh | input | N*VW | Thresholds; neuron i at bits [i*VW +: VW] |
| vmem_out | output | N*VW | Membrane potentials; neuron i at bits [i*VW +: VW] |
| fire_vec | output | N | One-hot spike vector, bit i is neuron i |
| fire_idx | output | IDXW | Binary index of the winner |
| fire_valid | output | 1 | A spike was produced on the last tick |

## Verification
The assertions assume two things about the inputs. First, `tick` comes from a single time base and never needs to be held longer than one cycle. Second, `syn_in`, `thresh`, `leak_shift` and `refr_len` are stable at the clock edge where `tick` is sampled. The bench satisfies both by changing every input on the falling edge and pulsing `tick` for exactly one cycle, with idle cycles between ticks.

The directed stimulus sets up ties, saturation and refractory holds in which the held neuron is driven with the largest possible input. A random phase then sweeps every leak shift, short and zero refractory lengths, and thresholds low enough that winners and inhibition occur often.

// File: rtl/lif_wta_layer.sv
module lif_wta_layer #(
  parameter int N  = 300,
  parameter int VW = 16,
  parameter int IW = 12,
  parameter int SW = 4,
  parameter int RW = 5,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [SW-1:0]     leak_shift,
  input  logic [RW-1:0]     refr_len,
  input  logic [N*IW-1:0]   syn_in,
  input  logic [N*VW-1:0]   thresh,
  output logic [N*VW-1:0]   vmem_out,
  output logic [N-1:0]      fire_vec,
  output logic [IDXW-1:0]   fire_idx,
  output logic              fire_valid
);

  logic [VW-1:0] vm   [N];
  logic [RW-1:0] rc   [N];
  logic [VW-1:0] nxt  [N];
  logic [N-1:0]  hold;
  logic [N-1:0]  cand;
  logic [N-1:0]  win_vec;
  logic [IDXW-1:0] win_idx;
  logic          win_any;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic [VW-1:0] kept;
      logic [VW:0]   sum;
      kept    = vm[i] - (vm[i] >> leak_shift);
      sum     = (VW+1)'(kept) + (VW+1)'(syn_in[i*IW +: IW]);
      nxt[i]  = sum[VW] ? {VW{1'b1}} : sum[VW-1:0];
      hold[i] = (rc[i] != '0);
      cand[i] = !hold[i] && (nxt[i] >= thresh[i*VW +: VW]);
    end
  end

  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    win_vec = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && !win_any) begin
        win_any    = 1'b1;
        win_idx    = IDXW'(i);
        win_vec[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        vm[i] <= '0;
        rc[i] <= '0;
      end
    end else if (tick) begin
      for (int i = 0; i < N; i++) begin
        if (hold[i]) begin
          vm[i] <= '0;
          rc[i] <= rc[i] - 1'b1;
        end else if (win_any) begin
          vm[i] <= '0;
          if (win_vec[i]) rc[i] <= refr_len;
        end else begin
          vm[i] <= nxt[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_vec   <= '0;
      fire_idx   <= '0;
      fire_valid <= 1'b0;
    end else begin
      fire_vec   <= tick ? win_vec : '0;
      fire_idx   <= (tick && win_any) ? win_idx : '0;
      fire_valid <= tick && win_any;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) vmem_out[i*VW +: VW] = vm[i];
  end

endmodule

// File: rtl/lif_wta_layer_chk.sv
module lif_wta_layer_chk #(
  parameter int N    = 300,
  parameter int VW   = 16,
  parameter int IDXW = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic [N*VW-1:0] vmem_out,
  input logic [N-1:0]    fire_vec,
  input logic [IDXW-1:0] fire_idx,
  input logic            fire_valid
);

  // R5: never more than one spike per tick
  a_r5_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_vec));

  // R7: valid flag agrees with the vector
  a_r7_valid_matches_vec: assert property (@(posedge clk) disable iff (!rst_n)
    fire_valid == (fire_vec != '0));

  // R7: index points at the set bit
  a_r7_idx_matches_vec: assert property (@(posedge clk) disable iff (!rst_n)
    fire_valid |-> (fire_vec == (N'(1) << fire_idx)));

  // R3 and R6: a spike leaves the whole layer at rest
  a_r6_layer_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    fire_valid |-> (vmem_out == '0));

  // R8: a cycle without a tick changes no potential
  a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(vmem_out));

  // R7: no spike output unless the previous cycle was a tick
  a_r7_fire_only_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (fire_vec == '0));

endmodule

bind lif_wta_layer lif_wta_layer_chk #(.N(N), .VW(VW), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .vmem_out(vmem_out),
  .fire_vec(fire_vec), .fire_idx(fire_idx), .fire_valid(fire_valid)
);

// File: tb/lif_wta_layer_bench.sv
module lif_wta_layer_bench;
  localparam int N = 8, VW = 12, IW = 10, SW = 4, RW = 3;
  localparam int IDXW = $clog2(N);
  localparam int VMAX = (1 << VW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [SW-1:0] leak_shift = '0;
  logic [RW-1:0] refr_len = '0;
  logic [N*IW-1:0] syn_in;
  logic [N*VW-1:0] thresh, vmem_out;
  logic [N-1:0] fire_vec;
  logic [IDXW-1:0] fire_idx;
  logic fire_valid;

  int in_cur[N], in_th[N];
  int mv[N], mr[N], nv[N];
  int e_vec, e_idx, e_val, win;
  int tests = 0, fails = 0;
  bit running = 0, done = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      syn_in[i*IW +: IW] = IW'(in_cur[i]);
      thresh[i*VW +: VW] = VW'(in_th[i]);
    end
  end

  lif_wta_layer #(.N(N), .VW(VW), .IW(IW), .SW(SW), .RW(RW)) u_lif_wta_layer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .leak_shift(leak_shift),
    .refr_len(refr_len), .syn_in(syn_in), .thresh(thresh),
    .vmem_out(vmem_out), .fire_vec(fire_vec), .fire_idx(fire_idx),
    .fire_valid(fire_valid));

  // behavioural reference, one step per clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin mv[i] = 0; mr[i] = 0; end
      e_vec = 0; e_idx = 0; e_val = 0;
    end else begin
      e_vec = 0; e_idx = 0; e_val = 0;
      if (tick) begin
        win = -1;
        for (int i = 0; i < N; i++) begin
          if (mr[i] > 0) nv[i] = 0;
          else begin
            nv[i] = mv[i] - (mv[i] >> int'(leak_shift)) + in_cur[i];
            if (nv[i] > VMAX) nv[i] = VMAX;
            if (win < 0 && nv[i] >= in_th[i]) win = i;
          end
        end
        for (int i = 0; i < N; i++) begin
          if (mr[i] > 0) begin mr[i]--; mv[i] = 0; end
          else if (win >= 0) begin
            mv[i] = 0;
            if (i == win) mr[i] = int'(refr_len);
          end else mv[i] = nv[i];
        end
        if (win >= 0) begin e_vec = 1 << win; e_idx = win; e_val = 1; end
      end
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int vm(int i);
    return int'(vmem_out[i*VW +: VW]);
  endfunction

  always @(negedge clk) begin
    if (running) begin
      int bad;
      bad = -1;
      for (int i = 0; i < N; i++) if (vm(i) != mv[i] && bad < 0) bad = i;
      chk(bad < 0, "R1 potential vs model", (bad < 0) ? 0 : vm(bad), (bad < 0) ? 0 : mv[bad]);
      chk(int'(fire_vec) == e_vec, "R5 fire_vec vs model", fire_vec, e_vec);
      chk(int'(fire_idx) == e_idx && int'(fire_valid) == e_val, "R7 fire_idx/valid vs model",
          fire_idx, e_idx);
    end
  end

  task automatic step();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [N*VW-1:0] snap;
    for (int i = 0; i < N; i++) begin in_cur[i] = 0; in_th[i] = VMAX; end
    repeat (3) @(negedge clk);
    chk(vmem_out == '0 && fire_vec == '0 && !fire_valid, "R9 reset state", fire_vec, 0);
    rst_n = 1'b1;
    running = 1;

    // R1: shift 0 drops the old potential
    leak_shift = 4'd0;
    for (int i = 0; i < N; i++) in_cur[i] = i * 10 + 5;
    step();
    chk(vm(7) == 75, "R1 shift zero", vm(7), 75);
    step();
    chk(vm(7) == 75, "R1 shift zero repeat", vm(7), 75);
    // R1: shift 1 halves, rounding toward keeping
    leak_shift = 4'd1;
    for (int i = 0; i < N; i++) in_cur[i] = 0;
    step();
    chk(vm(7) == 38, "R1 shift one", vm(7), 38);

    // R8: idle cycles
    snap = vmem_out;
    repeat (5) @(negedge clk);
    chk(vmem_out == snap && fire_vec == '0, "R8 no tick no change", vm(7), 38);

    // R2: saturation then fire at max threshold
    leak_shift = 4'd0;
    step();
    leak_shift = 4'd15;
    in_cur[3] = 1023; in_cur[5] = 100;
    repeat (4) step();
    chk(vm(3) == 4092, "R2 accumulate", vm(3), 4092);
    chk(vm(5) == 400, "R2 neighbour", vm(5), 400);
    step();
    chk(fire_valid && fire_idx == 3, "R2 saturated fire", fire_idx, 3);
    chk(vmem_out == '0, "R6 all cleared", vm(5), 0);

    // R5: tie, lowest index wins
    for (int i = 0; i < N; i++) in_cur[i] = 10;
    in_th[2] = 50; in_th[5] = 50; in_cur[2] = 60; in_cur[5] = 60;
    refr_len = 3'd3;
    step();
    chk(fire_vec == 8'b0000_0100 && fire_idx == 2, "R5 tie lowest index", fire_idx, 2);
    chk(vmem_out == '0, "R6 loser cleared", vm(5), 0);

    // R4: refractory hold ignores a full-scale input
    in_cur[5] = 0; in_cur[2] = 1023;
    for (int k = 0; k < 3; k++) begin
      step();
      chk(!fire_valid && vm(2) == 0, "R4 held neuron silent", vm(2), 0);
    end
    step();
    chk(fire_valid && fire_idx == 2, "R4 fires after hold", fire_idx, 2);

    // random sweep
    for (int t = 0; t < 600; t++) begin
      leak_shift = SW'($urandom_range(0, 15));
      refr_len = RW'($urandom_range(0, 7));
      for (int i = 0; i < N; i++) begin
        in_cur[i] = $urandom_range(0, 1023);
        in_th[i] = $urandom_range(300, VMAX);
      end
      step();
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    running = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule